// File: doc/BRIEF.md
# Programmable Front-End Step Sequencer

The block plays back a table of 16-bit state words to drive the strobes of an analog front end. Software loads the table through a simple write port while the block is idle. A start pulse then makes the block step through the entries in order. Each entry sets a group of control outputs and a duration. The duration is counted either on every fast-clock cycle or only on the cycles where a slow-clock enable pulse is present.

An entry whose stop flag is set ends the run after exactly one fast cycle. If no entry carries the stop flag, the run ends after the last table entry. At the end of a run, busy falls, done pulses for one cycle and every control output returns low. A test-select flag in each entry picks which of two externally supplied channel codes is driven out, and whether DAC register index 6 or 7 is reported.

Top module: `afe_step_sequencer`

## Requirements
- R1: After reset, busy, done and every control output are 0. While busy is 0, all control outputs stay 0, dac_reg_idx included.
- R2: A start pulse sampled while idle raises busy one cycle later and presents entry 0 on the outputs. The field positions are: bit 6 drives latch_en, bit 5 drives clk_on, bit 4 drives strobe_a, bit 3 drives strobe_b, bit 2 drives strobe_c, and bits 1:0 drive sel_chan.
- R3: An entry with bit 10 = 0 and bit 9 = 0 lasts (bits 15:11) + 1 fast cycles before the next entry appears.
- R4: An entry with bit 10 = 1 and bit 9 = 0 counts only the cycles in which slow_tick is high. It ends at the edge that samples its ((bits 15:11)+1)-th slow_tick.
- R5: An entry with bit 9 = 1 lasts exactly one fast cycle and ends the run, whatever bits 15:10 hold.
- R6: A table with no stop flag runs all 24 entries and then ends.
- R7: At the end of a run, busy falls and done is high for exactly one cycle, in the same cycle that busy falls.
- R8: dac_en during an entry equals bit 8 AND NOT dac_force_on, with dac_force_on sampled when the entry is loaded.
- R9: With bit 7 = 0, test_chan takes tch0 and dac_reg_idx is 6. With bit 7 = 1, test_chan takes tch1 and dac_reg_idx is 7.
- R10: Table writes and start pulses made while busy have no effect, neither on the current run nor on the table.
- R11: Every table entry resets to 0. A run started right after reset therefore lasts 24 fast cycles, with all outputs low except dac_reg_idx = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe (idle only) |
| wr_addr | input | 5 | Table entry address, 0..23 |
| wr_data | input | 16 | State word to store |
| start | input | 1 | Run trigger, honoured while idle |
| slow_tick | input | 1 | Slow-clock enable pulse, synchronous to clk |
| dac_force_on | input | 1 | Global DAC-always-on control; blocks the per-entry DAC bit |
| tch0 | input | 2 | Test channel code used when test-select is 0 |
| tch1 | input | 2 | Test channel code used when test-select is 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| dac_en | output | 1 | DAC enable strobe |
| latch_en | output | 1 | Output-latch enable strobe |
| clk_on | output | 1 | Front-end clock enable strobe |
| strobe_a | output | 1 | Control strobe from bit 4 |
| strobe_b | output | 1 | Control strobe from bit 3 |
| strobe_c | output | 1 | Control strobe from bit 2 |
| sel_chan | output | 2 | Channel select from bits 1:0 |
| test_chan | output | 2 | Test channel chosen by test-select |
| dac_reg_idx | output | 3 | DAC register index, 6 or 7, 0 while idle |

## Verification
A wrong duration counter or a wrong timebase choice changes how long each output pattern is held. This appears at the first entry boundary, so the bench counts busy cycles per output pattern and compares the counts with the field values. A wrong entry pointer or a corrupt table word shows up at the next load as a wrong strobe pattern or a wrong total run length. A missed end condition shows up as busy staying high past the expected cycle, or done lasting more than one cycle.

// File: rtl/afe_step_sequencer.sv
module afe_step_sequencer #(
  parameter int ENTRIES = 24,
  parameter int WORD_W  = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic              slow_tick,
  input  logic              dac_force_on,
  input  logic [1:0]        tch0,
  input  logic [1:0]        tch1,
  output logic              busy,
  output logic              done,
  output logic              dac_en,
  output logic              latch_en,
  output logic              clk_on,
  output logic              strobe_a,
  output logic              strobe_b,
  output logic              strobe_c,
  output logic [1:0]        sel_chan,
  output logic [1:0]        test_chan,
  output logic [2:0]        dac_reg_idx
);

  logic [WORD_W-1:0] tbl [ENTRIES];
  logic [AW-1:0]     ptr;
  logic [4:0]        cnt;
  logic              cur_slow, cur_stop;

  logic state_end, at_end, load, finish, step;
  logic [AW-1:0]     nptr;
  logic [WORD_W-1:0] nw;

  assign state_end = cur_stop | ((cnt == 5'd0) & (~cur_slow | slow_tick));
  assign at_end    = cur_stop | (ptr == AW'(ENTRIES - 1));
  assign load      = (~busy & start) | (busy & state_end & ~at_end);
  assign finish    = busy & state_end & at_end;
  assign step      = busy & ~state_end & (~cur_slow | slow_tick);
  assign nptr      = busy ? ptr + AW'(1) : '0;
  assign nw        = tbl[nptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (wr_en && !busy && (int'(wr_addr) < ENTRIES)) begin
      tbl[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      ptr         <= '0;
      cnt         <= '0;
      cur_slow    <= 1'b0;
      cur_stop    <= 1'b0;
      dac_en      <= 1'b0;
      latch_en    <= 1'b0;
      clk_on      <= 1'b0;
      strobe_a    <= 1'b0;
      strobe_b    <= 1'b0;
      strobe_c    <= 1'b0;
      sel_chan    <= '0;
      test_chan   <= '0;
      dac_reg_idx <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy        <= 1'b1;
        ptr         <= nptr;
        cnt         <= nw[15:11];
        cur_slow    <= nw[10];
        cur_stop    <= nw[9];
        dac_en      <= nw[8] & ~dac_force_on;
        test_chan   <= nw[7] ? tch1 : tch0;
        dac_reg_idx <= nw[7] ? 3'd7 : 3'd6;
        latch_en    <= nw[6];
        clk_on      <= nw[5];
        strobe_a    <= nw[4];
        strobe_b    <= nw[3];
        strobe_c    <= nw[2];
        sel_chan    <= nw[1:0];
      end else if (finish) begin
        busy        <= 1'b0;
        done        <= 1'b1;
        cur_slow    <= 1'b0;
        cur_stop    <= 1'b0;
        cnt         <= '0;
        dac_en      <= 1'b0;
        latch_en    <= 1'b0;
        clk_on      <= 1'b0;
        strobe_a    <= 1'b0;
        strobe_b    <= 1'b0;
        strobe_c    <= 1'b0;
        sel_chan    <= '0;
        test_chan   <= '0;
        dac_reg_idx <= '0;
      end else if (step) begin
        cnt <= cnt - 5'd1;
      end
    end
  end

endmodule

// File: rtl/afe_step_sequencer_chk.sv
module afe_step_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       dac_force_on,
  input logic       busy,
  input logic       done,
  input logic       dac_en,
  input logic       latch_en,
  input logic       clk_on,
  input logic       strobe_a,
  input logic       strobe_b,
  input logic       strobe_c,
  input logic [1:0] sel_chan,
  input logic [1:0] test_chan,
  input logic [2:0] dac_reg_idx
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ({dac_en, latch_en, clk_on, strobe_a, strobe_b, strobe_c,
                sel_chan, test_chan, dac_reg_idx} == '0));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_end_marks_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_dac_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(dac_force_on)) |-> !dac_en);

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dac_reg_idx == 3'd6 || dac_reg_idx == 3'd7));

endmodule

bind afe_step_sequencer afe_step_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dac_force_on(dac_force_on),
  .busy(busy), .done(done), .dac_en(dac_en), .latch_en(latch_en),
  .clk_on(clk_on), .strobe_a(strobe_a), .strobe_b(strobe_b),
  .strobe_c(strobe_c), .sel_chan(sel_chan), .test_chan(test_chan),
  .dac_reg_idx(dac_reg_idx)
);

// File: tb/tb_afe_step_sequencer.sv
module tb_afe_step_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, slow_tick = 1'b0, dac_force_on = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] tch0 = 2'd1, tch1 = 2'd2;
  logic busy, done, dac_en, latch_en, clk_on, strobe_a, strobe_b, strobe_c;
  logic [1:0] sel_chan, test_chan;
  logic [2:0] dac_reg_idx;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afe_step_sequencer dut (.*);

  function automatic logic [15:0] mk(int rep, bit slow, bit stp, bit dac, bit ts,
                                     bit lat, bit con, bit a, bit b, bit c, int ch);
    return {rep[4:0], slow, stp, dac, ts, lat, con, a, b, c, ch[1:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a[4:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_r1_r11();
    int n;
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check({dac_en, latch_en, clk_on, strobe_a, strobe_b, strobe_c, sel_chan, test_chan, dac_reg_idx} == 0,
          "R1 outputs", dac_reg_idx, 0);
    go();
    check(dac_reg_idx == 6 && latch_en == 0, "R11 zero entry", dac_reg_idx, 6);
    run_len(n);
    check(n == 24, "R11 run length", n, 24);
    check(done == 1, "R7 done at end", done, 1);
    @(negedge clk);
    check(done == 0, "R7 done one cycle", done, 0);
  endtask

  task automatic t_fields_r2();
    wr(0, mk(3, 1, 1, 0, 0, 1, 1, 1, 1, 1, 2));
    go();
    check(busy == 1, "R2 busy", busy, 1);
    check({latch_en, clk_on, strobe_a, strobe_b, strobe_c} == 5'b11111, "R2 strobes",
          {latch_en, clk_on, strobe_a, strobe_b, strobe_c}, 31);
    check(sel_chan == 2, "R2 sel_chan", sel_chan, 2);
    @(negedge clk);
    check(busy == 0 && done == 1, "R5 stop with slow/rep ignored", busy, 0);
    check({latch_en, clk_on, sel_chan} == 0, "R1 outputs cleared", sel_chan, 0);
  endtask

  task automatic t_fast_r3();
    int n0 = 0, n1 = 0, n2 = 0, tot = 0;
    wr(0, mk(4, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    wr(1, mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
    wr(2, mk(7, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0));
    go();
    while (busy && tot < 100) begin
      tot++;
      if (latch_en) n0++;
      if (clk_on) n1++;
      if (strobe_a) n2++;
      @(negedge clk);
    end
    check(n0 == 5, "R3 rep 4 length", n0, 5);
    check(n1 == 1, "R3 rep 0 length", n1, 1);
    check(n2 == 1, "R5 stop length", n2, 1);
    check(tot == 7, "R3 total", tot, 7);
  endtask

  task automatic t_slow_r4();
    int i = 0, n0 = 0, n1 = 0;
    wr(0, mk(2, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    wr(1, mk(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0));
    go();
    repeat (40) begin
      i++;
      if (busy && latch_en) n0++;
      if (busy && clk_on) n1++;
      slow_tick = (i % 4 == 3);
      @(negedge clk);
    end
    slow_tick = 1'b0;
    check(n0 == 11, "R4 slow state length", n0, 11);
    check(n1 == 1, "R4 following entry", n1, 1);
  endtask

  task automatic t_stop_slow_r5();
    int n;
    wr(0, mk(31, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0));
    go();
    run_len(n);
    check(n == 1, "R5 stop ignores rep/slow", n, 1);
  endtask

  task automatic t_full_r6();
    int n;
    for (int k = 0; k < 24; k++) wr(k, mk(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    go();
    run_len(n);
    check(n == 48, "R6 all 24 entries", n, 48);
    check(done == 1, "R7 done after full table", done, 1);
  endtask

  task automatic t_dac_r8();
    wr(0, mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    dac_force_on = 1'b0;
    go();
    check(dac_en == 1, "R8 dac on", dac_en, 1);
    @(negedge clk);
    dac_force_on = 1'b1;
    go();
    check(dac_en == 0, "R8 dac forced", dac_en, 0);
    @(negedge clk);
    dac_force_on = 1'b0;
  endtask

  task automatic t_test_r9();
    wr(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(1, mk(0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0));
    go();
    check(test_chan == 1 && dac_reg_idx == 6, "R9 select 0", {test_chan, dac_reg_idx}, 14);
    @(negedge clk);
    check(test_chan == 2 && dac_reg_idx == 7, "R9 select 1", {test_chan, dac_reg_idx}, 23);
    @(negedge clk);
    check(dac_reg_idx == 0, "R1 idx idle", dac_reg_idx, 0);
  endtask

  task automatic t_busy_r10();
    int n;
    wr(0, mk(31, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0));
    wr(1, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0));
    go();
    wr_en = 1'b1; wr_addr = 0; wr_data = mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    start = 1'b1;
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
      wr_en = 1'b0; start = 1'b0;
    end
    check(n == 33, "R10 run unaffected", n, 33);
    go();
    run_len(n);
    check(n == 33, "R10 table unchanged", n, 33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1_r11();
    t_fields_r2();
    t_fast_r3();
    t_slow_r4();
    t_stop_slow_r5();
    t_full_r6();
    t_dac_r8();
    t_test_r9();
    t_busy_r10();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule